// File: doc/BRIEF.md
# CAN bit-time timestamp counter

This block keeps a 16-bit time base for a CAN controller. The time base has three possible sources. It can be held at zero. It can count in units of a programmable number of CAN bit times. It can follow a free-running 16-bit counter supplied from outside. The bit-timing logic sends a one-cycle pulse for every bit time and a one-cycle pulse for each start of frame, whether the frame is received or transmitted. The block latches the current time base into a timestamp output on each of those frame pulses.

Software reaches two words through a simple write port: a configuration word and a counter word. The configuration word holds the source select and the prescaler. It accepts writes only while the controller is both in its initialization state and has configuration changes enabled. A write to the counter word restarts the internal count.

A sticky flag reports each wrap of the time base to zero. The flag ignores drops to zero that a software write causes. An interrupt controller watches the flag and clears it with a one-cycle pulse.

Top module: `can_tstamp_counter`

## Requirements
- R1: In increment mode with prescaler value P (4 bits, configuration word bits 19:16), the counter rises by one on every (P+1)-th bit-time pulse. The bit-time count starts from zero after any accepted configuration write or counter write.
- R2: The source select (configuration word bits 1:0) works as follows. Code 00 and code 11 hold the counter at 0. Code 01 selects prescaled counting. Code 10 selects the external input.
- R3: A configuration write (wrAddr = 0) changes the select and prescaler only when initMode and cfgEnable are both 1 in that cycle. Otherwise the configuration word is left unchanged.
- R4: On the clock edge where sofPulse is 1, tstampValue takes the counter value seen in that cycle, from either the internal or the external source. Otherwise tstampValue holds.
- R5: In increment mode, a write of any data to the counter word (wrAddr = 1) makes the counter 0 on the next edge.
- R6: In external mode, counterValue equals extCount in the same cycle, and counter-word writes have no effect.
- R7: When the counter goes from non-zero to zero without a counter write or configuration write at that edge, wrapFlag is 1 one cycle later. This covers both an internal rollover from 0xFFFF and an external drop to zero.
- R8: wrapFlag stays 1 until wrapClear is pulsed. If a new wrap and wrapClear fall in the same cycle, the flag stays 1.
- R9: If a counter write and a completing bit-time pulse land in the same cycle, the write wins. The counter becomes 0 and no wrap is flagged, even when the counter was 0xFFFF.
- R10: After reset, the configuration word, counter, timestamp and wrap flag are all 0.
- R11: cfgWord returns the select in bits 1:0 and the prescaler in bits 19:16. cntWord returns the counter in bits 15:0. All other bits read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse per CAN bit time |
| sofPulse | input | 1 | One-cycle pulse at start of each received or transmitted frame |
| extCount | input | 16 | External timer value |
| initMode | input | 1 | Controller is in initialization state |
| cfgEnable | input | 1 | Configuration changes enabled |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects configuration word, 1 selects counter word |
| wrData | input | 32 | Write data |
| wrapClear | input | 1 | One-cycle clear of the wrap flag |
| counterValue | output | 16 | Live time base |
| tstampValue | output | 16 | Time base latched at last start of frame |
| wrapFlag | output | 1 | Sticky wrap-around flag |
| cfgWord | output | 32 | Configuration word readback |
| cntWord | output | 32 | Counter word readback |

## Verification
The bench drives the prescaler through exact tick counts. A design with an off-by-one in the prescaler would step one pulse early or late. Restarting the count after a mid-period counter write exposes a design that keeps stale bit-time progress. A full 16-bit rollover checks that the flag is set. A second rollover with a counter write placed on the same edge checks that the write wins and that no wrap is reported; a design that compared only old and new values would flag a false wrap there. Other cases cover writes that are locked out, writes aimed at the counter in external mode, a mode switch from a non-zero value, and a clear that coincides with a new wrap.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  parameter int CNT_W  = 16;
  parameter int PRE_W  = 4;
  parameter int SEL_W  = 2;
  parameter int WORD_W = 32;
  parameter int PRE_LSB = 16;

  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO     = 2'b00,
    SRC_INC      = 2'b01,
    SRC_EXT      = 2'b10,
    SRC_ZERO_ALT = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic srcExt;
    logic suppressWrap;
  } dpStrobes_t;
endpackage

// File: rtl/tsc_control.sv
module tsc_control
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              initMode,
  input  logic              cfgEnable,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output dpStrobes_t        strobes,
  output logic [WORD_W-1:0] cfgWord
);
  srcSel_e          srcReg;
  logic [PRE_W-1:0] preReg;
  logic [PRE_W-1:0] preCnt;
  logic             cfgAccept;
  logic             cntWrite;
  logic             modeInc;
  logic             lastTick;
  srcSel_e          newSrc;

  assign newSrc    = srcSel_e'(wrData[SEL_W-1:0]);
  assign modeInc   = (srcReg == SRC_INC);
  assign cfgAccept = wrEn && !wrAddr && initMode && cfgEnable;
  assign cntWrite  = wrEn && wrAddr && modeInc;
  assign lastTick  = (preCnt == preReg);

  // Strobes towards the datapath: writes take priority over counting.
  always_comb begin
    strobes.cntClear     = cntWrite || (cfgAccept && newSrc != SRC_INC);
    strobes.cntInc       = modeInc && bitTick && lastTick && !cntWrite && !cfgAccept;
    strobes.srcExt       = (srcReg == SRC_EXT);
    strobes.suppressWrap = cntWrite || cfgAccept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= SRC_ZERO;
      preReg <= '0;
    end else if (cfgAccept) begin
      srcReg <= newSrc;
      preReg <= wrData[PRE_LSB +: PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (cfgAccept || cntWrite) begin
      preCnt <= '0;
    end else if (modeInc && bitTick) begin
      preCnt <= lastTick ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[SEL_W-1:0] = srcReg;
    cfgWord[PRE_LSB +: PRE_W] = preReg;
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] extCount,
  input  logic             sofPulse,
  input  logic             wrapClear,
  output logic [CNT_W-1:0] counterValue,
  output logic [CNT_W-1:0] tstampValue,
  output logic             wrapFlag
);
  logic [CNT_W-1:0] intCnt;
  logic [CNT_W-1:0] lastVal;
  logic             supLast;
  logic             wrapEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                intCnt <= '0;
    else if (strobes.cntClear) intCnt <= '0;
    else if (strobes.cntInc)   intCnt <= intCnt + 1'b1;
  end

  assign counterValue = strobes.srcExt ? extCount : intCnt;

  // A drop to zero is a wrap unless the previous edge carried a write.
  assign wrapEvent = (lastVal != '0) && (counterValue == '0) && !supLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastVal <= '0;
      supLast <= 1'b0;
    end else begin
      lastVal <= counterValue;
      supLast <= strobes.suppressWrap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wrapFlag <= 1'b0;
    else if (wrapEvent) wrapFlag <= 1'b1;
    else if (wrapClear) wrapFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tstampValue <= '0;
    else if (sofPulse) tstampValue <= counterValue;
  end
endmodule

// File: rtl/can_tstamp_counter.sv
module can_tstamp_counter
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              sofPulse,
  input  logic [CNT_W-1:0]  extCount,
  input  logic              initMode,
  input  logic              cfgEnable,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrapClear,
  output logic [CNT_W-1:0]  counterValue,
  output logic [CNT_W-1:0]  tstampValue,
  output logic              wrapFlag,
  output logic [WORD_W-1:0] cfgWord,
  output logic [WORD_W-1:0] cntWord
);
  dpStrobes_t strobes;

  tsc_control uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .initMode(initMode),
    .cfgEnable(cfgEnable), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .cfgWord(cfgWord)
  );

  tsc_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .extCount(extCount),
    .sofPulse(sofPulse), .wrapClear(wrapClear), .counterValue(counterValue),
    .tstampValue(tstampValue), .wrapFlag(wrapFlag)
  );

  always_comb begin
    cntWord = '0;
    cntWord[CNT_W-1:0] = counterValue;
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrAddr,
  input logic              initMode,
  input logic              cfgEnable,
  input logic              sofPulse,
  input logic [CNT_W-1:0]  extCount,
  input logic              wrapClear,
  input logic [WORD_W-1:0] cfgWord,
  input logic [CNT_W-1:0]  counterValue,
  input logic [CNT_W-1:0]  tstampValue,
  input logic              wrapFlag
);
  logic [SEL_W-1:0] sel;
  assign sel = cfgWord[SEL_W-1:0];

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && !(initMode && cfgEnable)) |=> $stable(cfgWord));

  a_r2_zero_source: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b00 || sel == 2'b11) |-> (counterValue == '0));

  a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b10) |-> (counterValue == extCount));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> (tstampValue == $past(counterValue)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wrapFlag && !wrapClear) |=> wrapFlag);

  a_r5_write_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr && sel == 2'b01) |=> (counterValue == '0));

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b01 && !wrEn) |=> (counterValue == $past(counterValue) ||
                                 counterValue == CNT_W'($past(counterValue) + 1'b1)));
endmodule

bind can_tstamp_counter tsc_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .initMode(initMode),
  .cfgEnable(cfgEnable), .sofPulse(sofPulse), .extCount(extCount),
  .wrapClear(wrapClear), .cfgWord(cfgWord), .counterValue(counterValue),
  .tstampValue(tstampValue), .wrapFlag(wrapFlag)
);

// File: tb/can_tstamp_counter_test.sv
`timescale 1ns/1ps
module can_tstamp_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0, sofPulse = 1'b0, initMode = 1'b0, cfgEnable = 1'b0;
  logic        wrEn = 1'b0, wrAddr = 1'b0, wrapClear = 1'b0;
  logic [15:0] extCount = 16'h0;
  logic [31:0] wrData = 32'h0;
  logic [15:0] counterValue, tstampValue;
  logic        wrapFlag;
  logic [31:0] cfgWord, cntWord;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_tstamp_counter uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .sofPulse(sofPulse),
    .extCount(extCount), .initMode(initMode), .cfgEnable(cfgEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrapClear(wrapClear),
    .counterValue(counterValue), .tstampValue(tstampValue), .wrapFlag(wrapFlag),
    .cfgWord(cfgWord), .cntWord(cntWord)
  );

  // Behavioural reference model, advanced on every rising edge.
  int mSel, mPre, mPreCnt, mCnt, mTs, mLast;
  bit mFlag, mSup;

  function automatic int modelValue();
    return (mSel == 2) ? int'(extCount) : mCnt;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel = 0; mPre = 0; mPreCnt = 0; mCnt = 0; mTs = 0; mLast = 0;
      mFlag = 0; mSup = 0;
    end else begin
      int cur;
      bit ev, cfgOk, cntWr;
      cur   = modelValue();
      ev    = (mLast != 0) && (cur == 0) && !mSup;
      cfgOk = wrEn && !wrAddr && initMode && cfgEnable;
      cntWr = wrEn && wrAddr && (mSel == 1);
      if (sofPulse) mTs = cur;
      if (ev) mFlag = 1; else if (wrapClear) mFlag = 0;
      mLast = cur;
      mSup  = cntWr || cfgOk;
      if (cfgOk) begin
        mSel = int'(wrData[1:0]);
        mPre = int'(wrData[19:16]);
        mPreCnt = 0;
        if (mSel != 1) mCnt = 0;
      end else if (cntWr) begin
        mCnt = 0; mPreCnt = 0;
      end else if (mSel == 1 && bitTick) begin
        if (mPreCnt == mPre) begin
          mPreCnt = 0;
          mCnt = (mCnt + 1) % 65536;
        end else mPreCnt = mPreCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(counterValue == 16'(modelValue()), "R2 counter value", counterValue, modelValue());
      check(tstampValue == 16'(mTs), "R4 timestamp", tstampValue, mTs);
      check(wrapFlag == mFlag, "R8 wrap flag", wrapFlag, mFlag);
      check(cfgWord == {12'h0, 4'(mPre), 14'h0, 2'(mSel)}, "R11 config readback",
            cfgWord, {12'h0, 4'(mPre), 14'h0, 2'(mSel)});
      check(cntWord == {16'h0, 16'(modelValue())}, "R11 counter readback",
            cntWord, modelValue());
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic writeReg(input bit addr, input logic [31:0] data);
    wrEn = 1; wrAddr = addr; wrData = data;
    cyc();
    wrEn = 0; wrData = 32'h0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin bitTick = 1; cyc(); bitTick = 0; cyc(); end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    // R10 reset state
    check(cfgWord == 0 && counterValue == 0 && tstampValue == 0 && wrapFlag == 0,
          "R10 reset state", {cfgWord, counterValue}, 0);
    rstN = 1;
    cyc(2);

    // R3 gated configuration writes
    cfgEnable = 1; writeReg(0, 32'h0003_0001);
    check(cfgWord == 0, "R3 locked without init", cfgWord, 0);
    initMode = 1; cfgEnable = 0; writeReg(0, 32'h0003_0001);
    check(cfgWord == 0, "R3 locked without enable", cfgWord, 0);
    cfgEnable = 1; writeReg(0, 32'hFFF3_FFFD);
    check(cfgWord == 32'h0003_0001, "R11 reserved bits zero", cfgWord, 32'h0003_0001);

    // R1 prescaler of 3 -> four bit times per step
    ticks(3);
    check(counterValue == 0, "R1 no step after 3 ticks", counterValue, 0);
    ticks(1);
    check(counterValue == 1, "R1 step after 4 ticks", counterValue, 1);
    ticks(4);
    check(counterValue == 2, "R1 second step", counterValue, 2);

    // R5 counter write restarts count and prescale progress
    ticks(2);
    writeReg(1, 32'hABCD_1234);
    check(counterValue == 0 && cntWord == 0, "R5 write clears", counterValue, 0);
    ticks(3);
    check(counterValue == 0, "R5 prescale restarted", counterValue, 0);
    ticks(1);
    check(counterValue == 1, "R5 first step after write", counterValue, 1);

    // R4 start-of-frame capture
    ticks(4);
    sofPulse = 1; cyc(); sofPulse = 0;
    check(tstampValue == 2, "R4 capture internal", tstampValue, 2);

    // R9 write coincides with completing tick
    ticks(3);
    bitTick = 1; wrEn = 1; wrAddr = 1; cyc(); bitTick = 0; wrEn = 0;
    check(counterValue == 0, "R9 write beats increment", counterValue, 0);
    cyc(2);
    check(wrapFlag == 0, "R9 no wrap from write", wrapFlag, 0);

    // R2 zero modes
    writeReg(0, 32'h0000_0000);
    ticks(20);
    check(counterValue == 0, "R2 select 00 holds zero", counterValue, 0);
    writeReg(0, 32'h0000_0003);
    extCount = 16'h4321; ticks(20);
    check(counterValue == 0, "R2 select 11 holds zero", counterValue, 0);

    // R6 external mode
    writeReg(0, 32'h0000_0002);
    extCount = 16'h1234; cyc();
    check(counterValue == 16'h1234, "R6 follows external", counterValue, 16'h1234);
    writeReg(1, 32'h0000_5555);
    check(counterValue == 16'h1234, "R6 write ignored", counterValue, 16'h1234);
    sofPulse = 1; cyc(); sofPulse = 0;
    check(tstampValue == 16'h1234, "R4 capture external", tstampValue, 16'h1234);

    // R7 external drop to zero
    extCount = 16'h0010; cyc(2);
    extCount = 16'h0000; cyc();
    check(wrapFlag == 1, "R7 external wrap", wrapFlag, 1);
    cyc(3);
    wrapClear = 1; cyc(); wrapClear = 0;
    check(wrapFlag == 0, "R8 clear", wrapFlag, 0);
    cyc(3);
    check(wrapFlag == 0, "R8 stays clear at zero", wrapFlag, 0);

    // R8 set wins over clear
    extCount = 16'h0005; cyc(2);
    extCount = 16'h0000; wrapClear = 1; cyc(); wrapClear = 0;
    check(wrapFlag == 1, "R8 set wins", wrapFlag, 1);
    wrapClear = 1; cyc(); wrapClear = 0;

    // R7 mode switch to zero is not a wrap
    extCount = 16'h0077; cyc(2);
    writeReg(0, 32'h0000_0000);
    cyc(2);
    check(wrapFlag == 0, "R7 config change no wrap", wrapFlag, 0);

    // R7 internal rollover with prescaler 0
    writeReg(0, 32'h0000_0001);
    bitTick = 1;
    for (int i = 0; i < 70000; i++) begin
      if (counterValue == 16'hFFFF) break;
      cyc();
    end
    cyc();
    check(counterValue == 0, "R7 rollover to zero", counterValue, 0);
    cyc();
    check(wrapFlag == 1, "R7 rollover flagged", wrapFlag, 1);
    wrapClear = 1; cyc(); wrapClear = 0;

    // R9 write at 0xFFFF on a completing tick
    for (int i = 0; i < 70000; i++) begin
      if (counterValue == 16'hFFFF) break;
      cyc();
    end
    wrEn = 1; wrAddr = 1; cyc(); wrEn = 0;
    check(counterValue == 0, "R9 write at top", counterValue, 0);
    cyc();
    check(wrapFlag == 0 && counterValue == 1, "R9 no wrap at top", wrapFlag, 0);
    bitTick = 0;
    cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule